// File: doc/BRIEF.md
# Shared Pin Arbiter for Multiple Cores

This block merges the output requests of several processor cores onto one bank of shared I/O pins. Every core presents an output bit and a drive-enable bit for every pin. With no owner, a pin merges all cores in one of two ways, chosen per pin. In OR mode, any core that presents a 1 makes the pin high. In AND mode, any core that presents a 0 makes the pin low. A per-pin inversion stage follows the merge, so a pin can rest high while every core rests low.

A core that needs a pin for itself, such as a chip select or a serial line, can claim that pin. A claim is granted only when the pin is free. Granting is atomic: if several cores ask for one free pin in the same cycle, the lowest core index wins and the others are refused. While a core owns a pin, that pin follows only the owner's output and enable bits. The owner gives the pin back with a release request.

Top module: `shared_pin_arbiter`

## Requirements
- R1: When a pin has no owner and is in OR mode (mode bit 0) without inversion, `pin_out` equals the OR of all cores' output bits for that pin whenever `pin_oe` is 1.
- R2: When a pin has no owner and is in AND mode (mode bit 1), the merged value is the AND of all cores' output bits for that pin, so one core at 0 forces the pin low.
- R3: With a pin's invert bit set, the merged value is inverted before it reaches `pin_out`. When `pin_oe` is 0, `pin_out` equals the pin's invert bit, which is its idle level.
- R4: When a pin has no owner, `pin_oe` is the OR of all cores' enable bits for that pin.
- R5: When a pin has an owner, `pin_out` and `pin_oe` follow only the owner's output and enable bits. The bits of all other cores have no effect.
- R6: A claim request gets exactly one response one cycle later, either `claim_grant` or `claim_deny`. The claim is granted only if the pin had no owner when the request was made. A granted core owns the pin from that same clock edge.
- R7: If several cores claim the same free pin in one cycle, only the lowest-index core is granted and every other requester is denied. Two cores are never granted the same pin.
- R8: A release from the owning core frees the pin at the next edge. A release from any other core is ignored, and the owner keeps the pin.
- R9: After synchronous reset, every pin has no owner, is in OR mode and is not inverted, and both response vectors are zero.
- R10: A configuration write (`cfg_we`=1) stores `cfg_and_mode` (1 = AND) and `cfg_invert` for pin `cfg_pin`. The new setting takes effect from the next cycle.
- R11: Claims by different cores on different free pins in the same cycle are all granted.
- R12: While a pin is owned, its owner does not change until that owner releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_out | input | NUM_CORES*NUM_PINS | Per-core output bits, [core][pin] |
| core_oe | input | NUM_CORES*NUM_PINS | Per-core drive enables, [core][pin] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin | input | PIN_W | Pin written by the configuration write |
| cfg_and_mode | input | 1 | Merge mode: 0 = OR, 1 = AND |
| cfg_invert | input | 1 | Invert the merged output |
| claim_req | input | NUM_CORES | Per-core claim request |
| claim_pin | input | NUM_CORES*PIN_W | Pin each core is claiming |
| rel_req | input | NUM_CORES | Per-core release request |
| rel_pin | input | NUM_CORES*PIN_W | Pin each core is releasing |
| claim_grant | output | NUM_CORES | Claim granted (registered) |
| claim_deny | output | NUM_CORES | Claim refused (registered) |
| pin_out | output | NUM_PINS | Pin drive values |
| pin_oe | output | NUM_PINS | Pin drive enables |

## Verification
The bound checker tests several rules on every cycle. Grant and deny never appear together. No response appears without a request. A granted core really holds the pin it asked for. No pin has more than one winner. The owner of a held pin stays fixed. A disabled pin sits at its idle level. An owned pin follows its owner's enable bit. Other behaviours need a model that runs across cycles, so only the bench's scenarios show them: the exact OR and AND merge values, the priority order under contention, a release from a non-owner being ignored, and the one-cycle delay before a configuration write takes effect.

// File: rtl/spa_pkg.sv
package spa_pkg;

    typedef enum logic {
        CMB_OR  = 1'b0,
        CMB_AND = 1'b1
    } cmb_mode_e;

    typedef struct packed {
        cmb_mode_e mode;
        logic      invert;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{mode: CMB_OR, invert: 1'b0};

    function automatic logic drive_level(logic merged, logic enabled, pin_cfg_t cfg);
        return enabled ? (merged ^ cfg.invert) : cfg.invert;
    endfunction

endpackage

// File: rtl/spa_cfg_regs.sv
module spa_cfg_regs
    import spa_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int PIN_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [PIN_W-1:0]         wpin,
    input  pin_cfg_t                 wcfg,
    output pin_cfg_t [NUM_PINS-1:0]  cfg_q
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[p] <= CFG_RESET;
            else if (we && wpin == PIN_W'(p))
                cfg_q[p] <= wcfg;
        end
    end

endmodule

// File: rtl/spa_owner_arb.sv
module spa_owner_arb #(
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 8,
    parameter int CORE_W    = 2,
    parameter int PIN_W     = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_CORES-1:0]             claim_req,
    input  logic [NUM_CORES-1:0][PIN_W-1:0]  claim_pin,
    input  logic [NUM_CORES-1:0]             rel_req,
    input  logic [NUM_CORES-1:0][PIN_W-1:0]  rel_pin,
    output logic [NUM_PINS-1:0]              held_q,
    output logic [NUM_PINS-1:0][CORE_W-1:0]  owner_q,
    output logic [NUM_CORES-1:0]             grant_q,
    output logic [NUM_CORES-1:0]             deny_q
);

    localparam logic [PIN_W:0] PIN_LIMIT = (PIN_W+1)'(NUM_PINS);

    logic [NUM_PINS-1:0]             held_n;
    logic [NUM_PINS-1:0][CORE_W-1:0] owner_n;
    logic [NUM_CORES-1:0]            grant_n;
    logic [NUM_CORES-1:0]            deny_n;
    logic [NUM_PINS-1:0]             taken;

    always_comb begin
        held_n  = held_q;
        owner_n = owner_q;
        grant_n = '0;
        deny_n  = '0;
        taken   = '0;
        // claims: scanning upward gives the lowest index priority
        for (int c = 0; c < NUM_CORES; c++) begin
            if (claim_req[c]) begin
                if ({1'b0, claim_pin[c]} < PIN_LIMIT &&
                    !held_q[claim_pin[c]] && !taken[claim_pin[c]]) begin
                    grant_n[c]             = 1'b1;
                    taken[claim_pin[c]]    = 1'b1;
                    held_n[claim_pin[c]]   = 1'b1;
                    owner_n[claim_pin[c]]  = CORE_W'(c);
                end else begin
                    deny_n[c] = 1'b1;
                end
            end
        end
        // releases only act on pins held before this edge by the requester
        for (int c = 0; c < NUM_CORES; c++) begin
            if (rel_req[c] && {1'b0, rel_pin[c]} < PIN_LIMIT &&
                held_q[rel_pin[c]] && owner_q[rel_pin[c]] == CORE_W'(c))
                held_n[rel_pin[c]] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            owner_q <= '0;
            grant_q <= '0;
            deny_q  <= '0;
        end else begin
            held_q  <= held_n;
            owner_q <= owner_n;
            grant_q <= grant_n;
            deny_q  <= deny_n;
        end
    end

endmodule

// File: rtl/spa_pin_merge.sv
module spa_pin_merge
    import spa_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 8,
    parameter int CORE_W    = 2
) (
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0] core_out,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0] core_oe,
    input  pin_cfg_t [NUM_PINS-1:0]            cfg,
    input  logic [NUM_PINS-1:0]                held,
    input  logic [NUM_PINS-1:0][CORE_W-1:0]    owner,
    output logic [NUM_PINS-1:0]                pin_out,
    output logic [NUM_PINS-1:0]                pin_oe
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic any_hi, all_hi, any_en, own_v, own_en, merged, enabled;

        always_comb begin
            any_hi = 1'b0;
            all_hi = 1'b1;
            any_en = 1'b0;
            own_v  = 1'b0;
            own_en = 1'b0;
            for (int c = 0; c < NUM_CORES; c++) begin
                any_hi = any_hi | core_out[c][p];
                all_hi = all_hi & core_out[c][p];
                any_en = any_en | core_oe[c][p];
                if (owner[p] == CORE_W'(c)) begin
                    own_v  = core_out[c][p];
                    own_en = core_oe[c][p];
                end
            end
            if (held[p]) begin
                merged  = own_v;
                enabled = own_en;
            end else begin
                merged  = (cfg[p].mode == CMB_AND) ? all_hi : any_hi;
                enabled = any_en;
            end
        end

        assign pin_out[p] = drive_level(merged, enabled, cfg[p]);
        assign pin_oe[p]  = enabled;
    end

endmodule

// File: rtl/shared_pin_arbiter.sv
module shared_pin_arbiter
    import spa_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 8,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0] core_out,
    input  logic [NUM_CORES-1:0][NUM_PINS-1:0] core_oe,
    input  logic                               cfg_we,
    input  logic [PIN_W-1:0]                   cfg_pin,
    input  logic                               cfg_and_mode,
    input  logic                               cfg_invert,
    input  logic [NUM_CORES-1:0]               claim_req,
    input  logic [NUM_CORES-1:0][PIN_W-1:0]    claim_pin,
    input  logic [NUM_CORES-1:0]               rel_req,
    input  logic [NUM_CORES-1:0][PIN_W-1:0]    rel_pin,
    output logic [NUM_CORES-1:0]               claim_grant,
    output logic [NUM_CORES-1:0]               claim_deny,
    output logic [NUM_PINS-1:0]                pin_out,
    output logic [NUM_PINS-1:0]                pin_oe
);

    pin_cfg_t                        wcfg;
    pin_cfg_t [NUM_PINS-1:0]         cfg_q;
    logic [NUM_PINS-1:0]             own_held;
    logic [NUM_PINS-1:0][CORE_W-1:0] own_core;

    assign wcfg = '{mode: cmb_mode_e'(cfg_and_mode), invert: cfg_invert};

    spa_cfg_regs #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we), .wpin(cfg_pin),
        .wcfg(wcfg), .cfg_q(cfg_q)
    );

    spa_owner_arb #(.NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS),
                    .CORE_W(CORE_W), .PIN_W(PIN_W)) arb_i (
        .clk(clk), .rst(rst),
        .claim_req(claim_req), .claim_pin(claim_pin),
        .rel_req(rel_req), .rel_pin(rel_pin),
        .held_q(own_held), .owner_q(own_core),
        .grant_q(claim_grant), .deny_q(claim_deny)
    );

    spa_pin_merge #(.NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS),
                    .CORE_W(CORE_W)) merge_i (
        .core_out(core_out), .core_oe(core_oe), .cfg(cfg_q),
        .held(own_held), .owner(own_core),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

endmodule

// File: rtl/spa_checker.sv
module spa_checker
    import spa_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_PINS  = 8,
    parameter int CORE_W    = 2,
    parameter int PIN_W     = 3
) (
    input logic                               clk,
    input logic                               rst,
    input logic [NUM_CORES-1:0][NUM_PINS-1:0] core_oe,
    input logic [NUM_CORES-1:0]               claim_req,
    input logic [NUM_CORES-1:0][PIN_W-1:0]    claim_pin,
    input logic [NUM_CORES-1:0]               claim_grant,
    input logic [NUM_CORES-1:0]               claim_deny,
    input logic [NUM_PINS-1:0]                pin_out,
    input logic [NUM_PINS-1:0]                pin_oe,
    input pin_cfg_t [NUM_PINS-1:0]            cfg_q,
    input logic [NUM_PINS-1:0]                own_held,
    input logic [NUM_PINS-1:0][CORE_W-1:0]    own_core
);

    logic [NUM_CORES-1:0]            req_d;
    logic [NUM_CORES-1:0][PIN_W-1:0] pin_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d <= '0;
            pin_d <= '0;
        end else begin
            req_d <= claim_req;
            pin_d <= claim_pin;
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        a_r6_single_response: assert property (@(posedge clk) disable iff (rst)
            !(claim_grant[c] && claim_deny[c]));
        a_r6_response_has_request: assert property (@(posedge clk) disable iff (rst)
            (claim_grant[c] || claim_deny[c]) |-> req_d[c]);
        a_r6_grant_takes_pin: assert property (@(posedge clk) disable iff (rst)
            claim_grant[c] |-> (own_held[pin_d[c]] && own_core[pin_d[c]] == CORE_W'(c)));
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [NUM_CORES-1:0] winners;
        always_comb begin
            for (int c = 0; c < NUM_CORES; c++)
                winners[c] = claim_grant[c] && pin_d[c] == PIN_W'(p);
        end
        a_r7_one_winner: assert property (@(posedge clk) disable iff (rst)
            $onehot0(winners));
        a_r12_owner_stable: assert property (@(posedge clk) disable iff (rst)
            (own_held[p] && $past(own_held[p])) |-> $stable(own_core[p]));
        a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
            !pin_oe[p] |-> pin_out[p] == cfg_q[p].invert);
        a_r5_owner_enable: assert property (@(posedge clk) disable iff (rst)
            own_held[p] |-> pin_oe[p] == core_oe[own_core[p]][p]);
    end

endmodule

bind shared_pin_arbiter spa_checker #(
    .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS), .CORE_W(CORE_W), .PIN_W(PIN_W)
) chk_i (
    .clk(clk), .rst(rst), .core_oe(core_oe),
    .claim_req(claim_req), .claim_pin(claim_pin),
    .claim_grant(claim_grant), .claim_deny(claim_deny),
    .pin_out(pin_out), .pin_oe(pin_oe), .cfg_q(cfg_q),
    .own_held(own_held), .own_core(own_core)
);

// File: tb/shared_pin_arbiter_tb_top.sv
`timescale 1ns/1ps
module shared_pin_arbiter_tb_top;

    localparam int NC = 4;
    localparam int NP = 8;
    localparam int CW = 2;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0][NP-1:0] core_out, core_oe;
    logic                  cfg_we, cfg_and_mode, cfg_invert;
    logic [PW-1:0]         cfg_pin;
    logic [NC-1:0]         claim_req, rel_req;
    logic [NC-1:0][PW-1:0] claim_pin, rel_pin;
    logic [NC-1:0]         claim_grant, claim_deny;
    logic [NP-1:0]         pin_out, pin_oe;

    always #2 clk = ~clk;

    shared_pin_arbiter #(.NUM_CORES(NC), .NUM_PINS(NP)) dut_i (
        .clk(clk), .rst(rst), .core_out(core_out), .core_oe(core_oe),
        .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_and_mode(cfg_and_mode),
        .cfg_invert(cfg_invert), .claim_req(claim_req), .claim_pin(claim_pin),
        .rel_req(rel_req), .rel_pin(rel_pin), .claim_grant(claim_grant),
        .claim_deny(claim_deny), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [NP-1:0] m_held = '0, m_and = '0, m_inv = '0;
    int            m_owner [NP];
    logic [NC-1:0] exp_gnt = '0, exp_dny = '0;
    bit            contended = 1'b0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic exp_merge(int p);
        logic v_or = 1'b0, v_and = 1'b1;
        if (m_held[p]) return core_out[m_owner[p]][p];
        for (int c = 0; c < NC; c++) begin
            v_or  |= core_out[c][p];
            v_and &= core_out[c][p];
        end
        return m_and[p] ? v_and : v_or;
    endfunction

    function automatic logic exp_en(int p);
        logic e = 1'b0;
        if (m_held[p]) return core_oe[m_owner[p]][p];
        for (int c = 0; c < NC; c++) e |= core_oe[c][p];
        return e;
    endfunction

    task automatic check_pins();
        for (int p = 0; p < NP; p++) begin
            logic en = exp_en(p);
            logic ov = en ? (exp_merge(p) ^ m_inv[p]) : m_inv[p];
            string t_oe = m_held[p] ? "R5" : "R4";
            string t_out = m_held[p] ? "R5" : (m_inv[p] ? "R3" : (m_and[p] ? "R2" : "R1"));
            chk(pin_oe[p] == en, t_oe, $sformatf("pin_oe[%0d]", p), pin_oe[p], en);
            chk(pin_out[p] == ov, t_out, $sformatf("pin_out[%0d]", p), pin_out[p], ov);
        end
    endtask

    // inputs are set by the caller at a negedge; this checks and advances one clock
    task automatic cycle();
        logic [NP-1:0] old_held;
        logic [NP-1:0] taken = '0;
        int old_owner [NP];
        int nreq [NP];
        #1;
        check_pins();
        old_held = m_held;
        for (int p = 0; p < NP; p++) begin old_owner[p] = m_owner[p]; nreq[p] = 0; end
        exp_gnt = '0; exp_dny = '0; contended = 1'b0;
        for (int c = 0; c < NC; c++)
            if (claim_req[c]) nreq[claim_pin[c]]++;
        for (int c = 0; c < NC; c++) begin
            if (claim_req[c]) begin
                int p = int'(claim_pin[c]);
                if (nreq[p] > 1) contended = 1'b1;
                if (!old_held[p] && !taken[p]) begin
                    exp_gnt[c] = 1'b1; taken[p] = 1'b1;
                    m_held[p] = 1'b1; m_owner[p] = c;
                end else exp_dny[c] = 1'b1;
            end
        end
        for (int c = 0; c < NC; c++) begin
            int p = int'(rel_pin[c]);
            if (rel_req[c] && old_held[p] && old_owner[p] == c) m_held[p] = 1'b0;
        end
        if (cfg_we) begin
            m_and[cfg_pin] = cfg_and_mode;
            m_inv[cfg_pin] = cfg_invert;
        end
        @(posedge clk);
        @(negedge clk);
        chk(claim_grant == exp_gnt, contended ? "R7" : "R6", "claim_grant", claim_grant, exp_gnt);
        chk(claim_deny == exp_dny, contended ? "R7" : "R6", "claim_deny", claim_deny, exp_dny);
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_pin = '0; cfg_and_mode = 0; cfg_invert = 0;
        claim_req = '0; claim_pin = '0; rel_req = '0; rel_pin = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WATCHDOG", "run did not complete", 0, 1);
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'h5EED_2468));
        for (int p = 0; p < NP; p++) m_owner[p] = 0;
        core_out = '0; core_oe = '0;
        idle_inputs();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state
        chk(pin_oe == '0, "R9", "pin_oe after reset", pin_oe, 0);
        chk(pin_out == '0, "R9", "pin_out after reset", pin_out, 0);
        chk(claim_grant == '0 && claim_deny == '0, "R9", "responses after reset",
            {claim_grant, claim_deny}, 0);
        @(negedge clk);

        // R1: OR merging with several patterns
        for (int k = 0; k < 4; k++) begin
            core_out = {$urandom, $urandom}; core_oe = {$urandom, $urandom};
            cycle();
        end

        // R10: configuration writes, effective the next cycle
        core_out = '1; core_out[2][1] = 1'b0; core_oe = '1;
        cfg_we = 1; cfg_pin = 3'd1; cfg_and_mode = 1; cfg_invert = 0;
        #1;
        chk(pin_out[1] == 1'b1, "R10", "pin 1 before AND write takes effect", pin_out[1], 1);
        cycle();
        cfg_we = 0;
        #1;
        chk(pin_out[1] == 1'b0, "R2", "pin 1 AND with one core low", pin_out[1], 0);
        cfg_we = 1; cfg_pin = 3'd2; cfg_and_mode = 0; cfg_invert = 1;
        cycle();
        cfg_we = 1; cfg_pin = 3'd3; cfg_and_mode = 1; cfg_invert = 1;
        cycle();
        cfg_we = 0;
        core_oe = '0;
        #1;
        chk(pin_out[2] == 1'b1, "R3", "pin 2 idle level when inverted", pin_out[2], 1);
        cycle();

        // R7 and R11: contention on pin 4, independent claim on pin 5
        core_out = {$urandom, $urandom}; core_oe = '1;
        claim_req = 4'b1011; claim_pin = {3'd4, 3'd5, 3'd4, 3'd4};
        claim_req[2] = 1'b1;
        cycle();
        chk(claim_grant == 4'b0101, "R11", "grants for pins 4 and 5", claim_grant, 4'b0101);
        claim_req = '0;

        // R8: release by a non-owner is ignored
        rel_req = 4'b0010; rel_pin = {3'd0, 3'd0, 3'd4, 3'd0};
        cycle();
        rel_req = '0;
        core_out = '0; core_out[0][4] = 1'b1; core_oe = '0; core_oe[0][4] = 1'b1;
        claim_req = 4'b1000; claim_pin = {3'd4, 3'd0, 3'd0, 3'd0};
        #1;
        chk(pin_oe[4] == 1'b1 && pin_out[4] == 1'b1, "R8", "pin 4 still follows core 0",
            {pin_oe[4], pin_out[4]}, 2'b11);
        cycle();
        chk(claim_deny == 4'b1000, "R8", "claim on still-owned pin 4", claim_deny, 4'b1000);

        // R8: release by the owner frees the pin
        claim_req = '0; rel_req = 4'b0001; rel_pin = '0; rel_pin[0] = 3'd4;
        cycle();
        rel_req = '0; claim_req = 4'b1000;
        cycle();
        chk(claim_grant == 4'b1000, "R8", "claim after owner release", claim_grant, 4'b1000);
        claim_req = '0;

        // random mix
        for (int k = 0; k < 3000; k++) begin
            core_out = {$urandom, $urandom};
            core_oe  = {$urandom, $urandom};
            idle_inputs();
            for (int c = 0; c < NC; c++) begin
                claim_req[c] = ($urandom % 4) == 0;
                claim_pin[c] = PW'($urandom % ((k % 2) ? 4 : NP));
                rel_req[c]   = ($urandom % 5) == 0;
                rel_pin[c]   = PW'($urandom % NP);
            end
            if ($urandom % 6 == 0) begin
                cfg_we = 1; cfg_pin = PW'($urandom % NP);
                cfg_and_mode = 1'($urandom); cfg_invert = 1'($urandom);
            end
            cycle();
        end

        done = 1'b1;
        finish_up();
    end

endmodule